// File: doc/BRIEF.md
# Dual 16-bit Counter/Timer with Prescalers and 32-bit Chaining

The block holds two identical 16-bit counter channels. A shared free-running divider produces a count tick on every fourth clock. Each channel passes that tick through its own 8-bit prescaler, so the channel takes one count step every 4*(P+1) clocks, where P is the channel's prescale value. A channel counts down from its reload value to zero, or up from zero to its reload value. At the end of the period it either wraps and keeps running or stops and holds its count. Each channel drives a pulse output whose duty cycle is set by a compare value. It also copies its count into a capture register on a rising input edge. Counting can be gated by a level input, and the start can be held until a trigger edge arrives.

Channel 1 can be chained to channel 0. In that case channel 1 takes one step each time channel 0 wraps, and the pair acts as one 32-bit counter. A read of channel 0's count copies channel 1's count into a shadow register. While chaining is on, channel 1's count address returns that shadow, so reading the low half and then the high half gives one coherent 32-bit value. Software uses a flat register port: writes take effect on the clock edge, and reads are combinational from `addr`.

Each channel is a four-state machine:
- IDLE: stopped after reset or after a stop write.
- ARMED: waiting for a trigger edge.
- RUN: counting.
- DONE: single-shot period finished.

The transitions are:
- start: a control write with the run bit set goes to ARMED if the trigger enable is set, and to RUN otherwise.
- stop: a control write with the run bit clear goes to IDLE from any state.
- fire: ARMED goes to RUN on a synchronized rising trigger edge.
- expire: RUN goes to DONE on a wrap step in single-shot mode.
- continuous mode stays in RUN at a wrap.

The address is {channel, field}: bit 3 selects the channel, and bits 2:0 select the field. The fields are 0 control, 1 reload, 2 compare, 3 count (read only), and 4 capture (read only). The control bits are:
- bit 0: run
- bit 1: up (1) or down (0)
- bit 2: continuous (1) or single-shot (0)
- bit 3: gate enable
- bit 4: trigger enable
- bit 6: chain (used only in channel 1)
- bits 15:8: prescale value P

Top module: `tmr_pair`

## Requirements
- R1: After reset, every readable field of both channels reads 0 and both pulse outputs are 0.
- R2: While running and not chained, a channel takes one count step every 4*(P+1) clocks, where P is control bits 15:8.
- R3: In down mode, start loads the reload value, each step decrements, and a step at 0 is a wrap that reloads the reload value in continuous mode.
- R4: In up mode, start loads 0, each step increments, and a step at the reload value is a wrap that loads 0 in continuous mode.
- R5: In single-shot mode (bit 2 = 0), the wrap step stops the channel (DONE), and the count holds its terminal value: 0 when counting down, the reload value when counting up.
- R6: The pulse output is cleared at start and at every wrap, and set on a step whose new count equals the compare value.
- R7: A rising edge on a channel's capture pin, after a two-flop synchronizer, copies the current count into that channel's capture register.
- R8: With the gate enable set (bit 3), the channel steps only while its synchronized gate pin is high, and its count holds while the pin is low.
- R9: With the trigger enable set (bit 4), a start write loads the start value and then waits (ARMED) with the count held until a synchronized rising edge on the trigger pin.
- R10: With the chain bit set in channel 1 (bit 6), channel 1 takes exactly one step per wrap of channel 0 and ignores its own prescale value.
- R11: A read strobe (`rd_en`) at channel 0's count address copies channel 1's count into the shadow register. While chained, channel 1's count address reads the shadow, which does not change until the next such strobe.
- R12: A control write with bit 0 clear stops the channel, and its count holds.
- R13: Writes to the count and capture addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read strobe; at channel 0 count address it loads the shadow |
| addr | input | 4 | {channel, field} register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| gate_i | input | 2 | Per-channel gate level pins |
| trig_i | input | 2 | Per-channel trigger pins |
| cap_i | input | 2 | Per-channel capture pins |
| pwm_o | output | 2 | Per-channel pulse outputs |

## Verification
The hardest situation to reach from the ports is a chained run where the count of channel 0 wraps must be known exactly. The bench needs that count to predict the high half and to show that the shadow stays frozen while the live high counter moves.

The bench sets channel 0's compare value one above zero in down mode. Each wrap then shows up as a falling edge on `pwm_o[0]`, and the bench counts those edges. It snapshots the count right after each start write, so the clear caused by the start is not counted as a wrap. It stops channel 0 before latching, so the total is final. It then reads the high half through the shadow twice: once before a new latch strobe, to show the value is still the old one, and once after it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_CNT_W = 16;
    localparam int TMR_PSC_W = 8;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_RUN   = 2'd2,
        S_DONE  = 2'd3
    } tmr_state_e;

    typedef struct packed {
        logic [TMR_PSC_W-1:0] psc;
        logic                 spare1;
        logic                 casc;
        logic                 spare0;
        logic                 trig_en;
        logic                 gate_en;
        logic                 cont;
        logic                 up;
        logic                 run;
    } tmr_ctrl_t;

    localparam logic [2:0] F_CTRL = 3'd0;
    localparam logic [2:0] F_RLD  = 3'd1;
    localparam logic [2:0] F_CMP  = 3'd2;
    localparam logic [2:0] F_CNT  = 3'd3;
    localparam logic [2:0] F_CAP  = 3'd4;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int W    = 1,
    parameter bit EDGE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    generate
        if (EDGE) begin : g_edge
            logic [W-1:0] s3_q;
            always_ff @(posedge clk) begin
                if (!rst_n) s3_q <= '0;
                else        s3_q <= s2_q;
            end
            assign q_o = s2_q & ~s3_q;

            // R7: a detected edge lasts exactly one cycle
            assert_edge_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (q_o != '0) |=> ((q_o & $past(q_o)) == '0));
        end else begin : g_level
            assign q_o = s2_q;
        end
    endgenerate

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         tick_i,
    input  logic [W-1:0] lim_i,
    output logic         step_o
);

    logic [W-1:0] cnt_q;

    assign step_o = tick_i && (cnt_q == lim_i);

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (tick_i) cnt_q <= step_o ? '0 : cnt_q + W'(1);
    end

    assert_psc_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_i);

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = TMR_CNT_W,
    parameter int PSC_W = TMR_PSC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             casc_sel_i,
    input  logic             casc_step_i,
    input  logic             ctrl_wr_i,
    input  logic             new_run_i,
    input  logic             new_up_i,
    input  logic             new_trig_i,
    input  logic             up_i,
    input  logic             cont_i,
    input  logic             gate_en_i,
    input  logic [PSC_W-1:0] psc_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [CNT_W-1:0] compare_i,
    input  logic             gate_i,
    input  logic             trig_rise_i,
    input  logic             cap_rise_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cap_o,
    output logic             pwm_o,
    output logic             tc_o
);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cap_q, start_v, nxt_v;
    logic             pwm_q, en, psc_step, step, at_term;

    assign en      = (state_q == S_RUN) && (!gate_en_i || gate_i);
    assign start_v = up_i ? '0 : reload_i;
    assign nxt_v   = up_i ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
    assign at_term = up_i ? (cnt_q == reload_i) : (cnt_q == '0);

    tmr_prescale #(.W(PSC_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (ctrl_wr_i),
        .tick_i (tick_i && en && !casc_sel_i),
        .lim_i  (psc_i),
        .step_o (psc_step)
    );

    assign step = !ctrl_wr_i && (casc_sel_i ? (casc_step_i && en) : psc_step);
    assign tc_o = step && at_term;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = S_IDLE;
            S_DONE:  state_d = S_DONE;
            S_ARMED: if (trig_rise_i) state_d = S_RUN;
            S_RUN:   if (tc_o && !cont_i) state_d = S_DONE;
        endcase
        if (ctrl_wr_i) begin
            if (!new_run_i)      state_d = S_IDLE;
            else if (new_trig_i) state_d = S_ARMED;
            else                 state_d = S_RUN;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // count, pulse output, capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pwm_q <= 1'b0;
            cap_q <= '0;
        end else begin
            if (ctrl_wr_i) begin
                if (new_run_i) begin
                    cnt_q <= new_up_i ? '0 : reload_i;
                    pwm_q <= 1'b0;
                end
            end else if (step) begin
                if (at_term) begin
                    pwm_q <= 1'b0;
                    if (cont_i) cnt_q <= start_v;
                end else begin
                    cnt_q <= nxt_v;
                    if (nxt_v == compare_i) pwm_q <= 1'b1;
                end
            end
            if (cap_rise_i) cap_q <= cnt_q;
        end
    end

    assign cnt_o = cnt_q;
    assign cap_o = cap_q;
    assign pwm_o = pwm_q;

    assert_single_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o && !cont_i) |=> (state_q == S_DONE) && $stable(cnt_q));

    assert_wrap_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |=> !pwm_q);

    assert_armed_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ARMED && !ctrl_wr_i) |=> $stable(cnt_q));

    assert_stopped_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_IDLE || state_q == S_DONE) && !ctrl_wr_i)
            |=> $stable(cnt_q) && (state_q == $past(state_q)));

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int CNT_W = TMR_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [3:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    input  logic [1:0]       gate_i,
    input  logic [1:0]       trig_i,
    input  logic [1:0]       cap_i,
    output logic [1:0]       pwm_o
);

    localparam int NCH    = 2;
    localparam int CTRL_W = $bits(tmr_ctrl_t);

    logic [1:0]       div_q;
    logic             tick;
    logic             ch;
    logic [2:0]       fld;
    tmr_ctrl_t        new_ctrl;
    tmr_ctrl_t        ctrl_q [NCH];
    logic [CNT_W-1:0] rld_q  [NCH];
    logic [CNT_W-1:0] cmp_q  [NCH];
    logic [CNT_W-1:0] cnt    [NCH];
    logic [CNT_W-1:0] cap    [NCH];
    logic [CNT_W-1:0] shadow_q;
    logic [NCH-1:0]   tc, wr_ctrl, casc_sel, casc_step, gate_s, trig_r, cap_r;
    logic [2*NCH-1:0] evt_r;

    assign ch       = addr[3];
    assign fld      = addr[2:0];
    assign new_ctrl = tmr_ctrl_t'(wdata[CTRL_W-1:0]);
    assign tick     = &div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 2'd1;
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NCH; k++) begin
                ctrl_q[k] <= '0;
                rld_q[k]  <= '0;
                cmp_q[k]  <= '0;
            end
        end else if (wr_en) begin
            case (fld)
                F_CTRL:  ctrl_q[ch] <= new_ctrl;
                F_RLD:   rld_q[ch]  <= wdata;
                F_CMP:   cmp_q[ch]  <= wdata;
                default: ;
            endcase
        end
    end

    // high-half shadow for coherent 32-bit reads
    always_ff @(posedge clk) begin
        if (!rst_n)                                shadow_q <= '0;
        else if (rd_en && !ch && (fld == F_CNT))   shadow_q <= cnt[1];
    end

    always_comb begin
        rdata = '0;
        case (fld)
            F_CTRL:  rdata = CNT_W'(ctrl_q[ch]);
            F_RLD:   rdata = rld_q[ch];
            F_CMP:   rdata = cmp_q[ch];
            F_CNT:   rdata = (ch && ctrl_q[1].casc) ? shadow_q : cnt[ch];
            F_CAP:   rdata = cap[ch];
            default: rdata = '0;
        endcase
    end

    tmr_sync #(.W(NCH), .EDGE(1'b0)) u_gate_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (gate_i),
        .q_o   (gate_s)
    );

    tmr_sync #(.W(2*NCH), .EDGE(1'b1)) u_evt_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cap_i, trig_i}),
        .q_o   (evt_r)
    );

    assign trig_r    = evt_r[NCH-1:0];
    assign cap_r     = evt_r[2*NCH-1:NCH];
    assign casc_sel  = {ctrl_q[1].casc, 1'b0};
    assign casc_step = {tc[0], 1'b0};

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            assign wr_ctrl[i] = wr_en && (ch == 1'(i)) && (fld == F_CTRL);

            tmr_chan #(.CNT_W(CNT_W), .PSC_W(TMR_PSC_W)) u_ch (
                .clk         (clk),
                .rst_n       (rst_n),
                .tick_i      (tick),
                .casc_sel_i  (casc_sel[i]),
                .casc_step_i (casc_step[i]),
                .ctrl_wr_i   (wr_ctrl[i]),
                .new_run_i   (new_ctrl.run),
                .new_up_i    (new_ctrl.up),
                .new_trig_i  (new_ctrl.trig_en),
                .up_i        (ctrl_q[i].up),
                .cont_i      (ctrl_q[i].cont),
                .gate_en_i   (ctrl_q[i].gate_en),
                .psc_i       (ctrl_q[i].psc),
                .reload_i    (rld_q[i]),
                .compare_i   (cmp_q[i]),
                .gate_i      (gate_s[i]),
                .trig_rise_i (trig_r[i]),
                .cap_rise_i  (cap_r[i]),
                .cnt_o       (cnt[i]),
                .cap_o       (cap[i]),
                .pwm_o       (pwm_o[i]),
                .tc_o        (tc[i])
            );

            // R3/R4: a wrap never occurs on two consecutive cycles
            assert_wrap_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
                tc[i] |=> !tc[i]);
        end
    endgenerate

    assert_shadow_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == {1'b0, F_CNT}) |=> (shadow_q == $past(cnt[1])));

    assert_chain_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[1].casc && !tc[0] && !(wr_en && ch)) |=> $stable(cnt[1]));

endmodule

// File: tb/tmr_pair_tb.sv
module tmr_pair_tb;

    localparam int C_RUN  = 1;
    localparam int C_UP   = 2;
    localparam int C_CONT = 4;
    localparam int C_GATE = 8;
    localparam int C_TRIG = 16;
    localparam int C_CASC = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  gate_i = '0;
    logic [1:0]  trig_i = '0;
    logic [1:0]  cap_i = '0;
    logic [1:0]  pwm_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int wraps  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tmr_pair u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .gate_i (gate_i),
        .trig_i (trig_i),
        .cap_i  (cap_i),
        .pwm_o  (pwm_o)
    );

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge pwm_o[0]) if (rst_n) wraps = wraps + 1;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(int ch, int fld, int data);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = 4'(ch * 8 + fld);
        wdata = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int ch, int fld, output int v);
        addr = 4'(ch * 8 + fld);
        #1;
        v = int'(rdata);
    endtask

    task automatic rd_latch();
        @(negedge clk);
        addr  = 4'd3;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic next_val(int ch, int prev, output int v, output int at);
        int n = 0;
        addr = 4'(ch * 8 + 3);
        v = prev;
        while (v == prev && n < 5000) begin
            @(negedge clk);
            #1;
            v = int'(rdata);
            n++;
        end
        at = cyc;
    endtask

    task automatic t_reset();
        int v;
        for (int c = 0; c < 2; c++)
            for (int f = 0; f < 5; f++) begin
                rd(c, f, v);
                chk($sformatf("R1 reset ch%0d field%0d", c, f), v, 0);
            end
        chk("R1 reset pwm", int'(pwm_o), 0);
    endtask

    task automatic t_rate(int p);
        int v0, v1, v2, c1, c2;
        wr(0, 1, 1000);
        wr(0, 0, C_RUN | C_CONT | (p << 8));
        rd(0, 3, v0);
        chk("R3 down start loads reload", v0, 1000);
        next_val(0, v0, v1, c1);
        next_val(0, v1, v2, c2);
        chk($sformatf("R2 step interval psc=%0d", p), c2 - c1, 4 * (p + 1));
        chk("R3 two decrements", v2, 998);
    endtask

    task automatic t_down_wrap();
        int exp_s[6] = '{1, 0, 2, 1, 0, 2};
        int v, at;
        wr(0, 1, 2);
        wr(0, 0, C_RUN | C_CONT);
        rd(0, 3, v);
        chk("R3 down start", v, 2);
        for (int k = 0; k < 6; k++) begin
            next_val(0, v, v, at);
            chk($sformatf("R3 down sequence #%0d", k), v, exp_s[k]);
        end
    endtask

    task automatic t_up_wrap();
        int exp_s[5] = '{1, 2, 3, 0, 1};
        int v, at;
        wr(0, 1, 3);
        wr(0, 0, C_RUN | C_CONT | C_UP);
        rd(0, 3, v);
        chk("R4 up start", v, 0);
        for (int k = 0; k < 5; k++) begin
            next_val(0, v, v, at);
            chk($sformatf("R4 up sequence #%0d", k), v, exp_s[k]);
        end
    endtask

    task automatic t_single();
        int v, at;
        wr(0, 1, 2);
        wr(0, 0, C_RUN);
        next_val(0, 2, v, at);
        next_val(0, v, v, at);
        chk("R5 single down reaches 0", v, 0);
        repeat (60) @(negedge clk);
        rd(0, 3, v);
        chk("R5 single down holds 0", v, 0);
        wr(0, 0, C_RUN | C_UP);
        next_val(0, 0, v, at);
        next_val(0, v, v, at);
        chk("R5 single up reaches reload", v, 2);
        repeat (60) @(negedge clk);
        rd(0, 3, v);
        chk("R5 single up holds reload", v, 2);
    endtask

    task automatic t_pwm();
        int v, at;
        wr(0, 1, 5);
        wr(0, 2, 2);
        wr(0, 0, C_RUN | C_CONT);
        rd(0, 3, v);
        chk("R6 pwm low at start", int'(pwm_o[0]), 0);
        for (int k = 0; k < 12; k++) begin
            next_val(0, v, v, at);
            chk($sformatf("R6 pwm at count %0d", v), int'(pwm_o[0]), (v <= 2) ? 1 : 0);
        end
    endtask

    task automatic t_capture_stop();
        int v, w;
        wr(0, 1, 500);
        wr(0, 0, C_RUN | (255 << 8));
        wr(0, 0, 0);
        rd(0, 3, v);
        chk("R12 stopped count held at start value", v, 500);
        @(negedge clk);
        cap_i[0] = 1'b1;
        repeat (3) @(negedge clk);
        cap_i[0] = 1'b0;
        repeat (6) @(negedge clk);
        rd(0, 4, v);
        chk("R7 capture copies count", v, 500);
        rd(1, 4, v);
        chk("R7 other channel capture untouched", v, 0);
        wr(0, 1, 1000);
        wr(0, 0, C_RUN | C_CONT);
        repeat (30) @(negedge clk);
        wr(0, 0, 0);
        rd(0, 3, v);
        chk("R12 count moved before stop", (v < 1000) ? 1 : 0, 1);
        repeat (60) @(negedge clk);
        rd(0, 3, w);
        chk("R12 count holds after stop", w, v);
        wr(0, 3, 16'h1234);
        wr(0, 4, 16'h4321);
        rd(0, 3, w);
        chk("R13 write to count ignored", w, v);
        rd(0, 4, w);
        chk("R13 write to capture ignored", w, 500);
    endtask

    task automatic t_gate();
        int v, a, b;
        gate_i[0] = 1'b0;
        wr(0, 1, 300);
        wr(0, 0, C_RUN | C_CONT | C_GATE);
        repeat (80) @(negedge clk);
        rd(0, 3, v);
        chk("R8 gate low holds count", v, 300);
        gate_i[0] = 1'b1;
        repeat (80) @(negedge clk);
        rd(0, 3, v);
        chk("R8 gate high counts", (v < 300) ? 1 : 0, 1);
        gate_i[0] = 1'b0;
        repeat (5) @(negedge clk);
        rd(0, 3, a);
        repeat (80) @(negedge clk);
        rd(0, 3, b);
        chk("R8 gate low again holds", b, a);
    endtask

    task automatic t_trigger();
        int v;
        wr(0, 1, 300);
        wr(0, 0, C_RUN | C_CONT | C_TRIG);
        repeat (80) @(negedge clk);
        rd(0, 3, v);
        chk("R9 armed holds start value", v, 300);
        trig_i[0] = 1'b1;
        repeat (2) @(negedge clk);
        trig_i[0] = 1'b0;
        repeat (80) @(negedge clk);
        rd(0, 3, v);
        chk("R9 runs after trigger edge", (v < 300) ? 1 : 0, 1);
    endtask

    task automatic t_chain();
        int v, base, w1, w2;
        wr(1, 1, 100);
        wr(1, 0, C_RUN | C_CONT | C_CASC | (5 << 8));
        wr(0, 1, 3);
        wr(0, 2, 1);
        wr(0, 0, C_RUN | C_CONT);
        base = wraps;
        repeat (200) @(negedge clk);
        wr(0, 0, 0);
        w1 = wraps - base;
        chk("R10 low half wrapped", (w1 > 0) ? 1 : 0, 1);
        rd_latch();
        rd(1, 3, v);
        chk("R10 high steps once per low wrap", v, 100 - w1);
        wr(0, 0, C_RUN | C_CONT);
        base = wraps;
        repeat (100) @(negedge clk);
        rd(1, 3, v);
        chk("R11 shadow unchanged without latch", v, 100 - w1);
        wr(0, 0, 0);
        w2 = wraps - base;
        rd_latch();
        rd(1, 3, v);
        chk("R11 latched high half coherent", v, 100 - w1 - w2);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rate(0);
        t_rate(2);
        t_down_wrap();
        t_up_wrap();
        t_single();
        t_pwm();
        t_capture_stop();
        t_gate();
        t_trigger();
        t_chain();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog all-R actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule